// File: doc/BRIEF.md
# Sequenced Multi-Condition Trigger

This block fires a trigger only after a series of input conditions has been seen one after another. Each condition is a pair of equal-width vectors: a mask that selects which trigger input bits matter, and a pattern that gives the value those bits must show. Software or an upstream agent pushes the pairs into a small queue. A controller takes them from the queue one at a time and waits for each to be met, in the order they were pushed. When the last queued condition is met, the trigger output rises and stays high.

A force input raises the trigger at once, whatever the controller is doing and whether detection is enabled or not. A trigger-clear input drops the trigger and the armed flag at once and returns the controller to its idle state. Entries still in the queue are kept, so a new chain can be loaded while the trigger is high and then started with a clear. The enable input only gates condition detection. The active-low reset acts asynchronously and empties the queue. Its release passes through a two-stage synchronizer, so the block starts accepting writes on the third rising edge after `rst_n` goes high.

Top module: `seq_chain_trigger`

## Requirements
- R1: While `rst_n` is low, and after its release until the first condition is written, `fired`, `armed` and `cfg_full` are 0, and the queue is empty.
- R2: The queue holds 2^FIFO_P pairs. `cfg_full` is 1 while it holds that many. A write made while it is full is dropped and is never used as a condition.
- R3: With the controller idle, a write at a clock edge makes `armed` rise two edges later. `armed` is 1 only while a condition is loaded and awaited, and it is never 1 at the same time as `fired`.
- R4: While a condition is awaited and `enable` is 1, it counts as met at a rising edge when, for every bit i with mask bit i = 1, `trig_in` bit i equals pattern bit i. Bits with mask bit 0 are ignored.
- R5: Conditions are taken in write order. When a condition is met and more pairs are queued, `armed` is 0 for exactly one cycle while the next pair is loaded, and then returns to 1. An input that satisfies only a later condition does not advance the chain.
- R6: While `enable` is 0, an awaited condition is never met: `armed` stays 1 and `fired` stays 0.
- R7: While `trig_force` is 1 and `trig_rst` is 0, `fired` is 1 in the same cycle, whatever the state and whatever `enable` is. The controller is in the fired state after the next edge.
- R8: While `trig_rst` is 1, `fired` and `armed` are 0 in the same cycle, even if `trig_force` is also 1. After the next edge the controller is idle.
- R9: Once the last condition has been met, or after a force, `fired` stays 1 until `trig_rst` or `rst_n` is asserted.
- R10: A condition with an all-zero mask is met at the first edge at which it is awaited with `enable` set, whatever `trig_in` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also empties the queue |
| cfg_wr | input | 1 | Write strobe for one condition pair |
| cfg_pattern | input | TRIG_W | Pattern of the pair being written |
| cfg_mask | input | TRIG_W | Mask of the pair being written (1 = bit compared) |
| cfg_full | output | 1 | Queue holds 2^FIFO_P pairs |
| trig_in | input | TRIG_W | Trigger input vector |
| enable | input | 1 | Enables condition detection |
| trig_force | input | 1 | Forces the trigger high immediately |
| trig_rst | input | 1 | Clears the trigger and returns the controller to idle |
| fired | output | 1 | Trigger output |
| armed | output | 1 | A condition is loaded and awaited |

## Verification
The assertions assume that `trig_in`, `enable`, `trig_force` and `trig_rst` are synchronous to `clk` and settle before each rising edge. The combinational paths from `trig_force` and `trig_rst` to the outputs are therefore checked only at sampling points. The bench drives every input shortly after a rising edge and samples the outputs after they settle. The match test sweeps every mask, pattern and input value of a 4-bit configuration, one condition at a time. Directed sequences cover chain order, the dropped write into a full queue, and the interaction of force and clear.

// File: rtl/seq_chain_trigger_pkg.sv
package seq_chain_trigger_pkg;

  // Controller states; encoding is free, no neighbour decodes it
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIRED = 2'd3
  } chain_state_e;

endpackage

// File: rtl/trig_cond_fifo.sv
module trig_cond_fifo #(
  parameter int W = 8,
  parameter int P = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_pat,
  input  logic [W-1:0] push_msk,
  input  logic         pop,
  output logic [W-1:0] head_pat,
  output logic [W-1:0] head_msk,
  output logic         empty,
  output logic         full
);
  localparam int DEPTH = 1 << P;
  localparam int EW    = 2 * W;

  logic [P:0]    wr_ptr, rd_ptr;
  logic [EW-1:0] slots [DEPTH];
  logic          do_push, do_pop;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[P] != rd_ptr[P]) && (wr_ptr[P-1:0] == rd_ptr[P-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // Storage carries no reset; only entries between the pointers are read
  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr[P-1:0]] <= {push_pat, push_msk};
  end

  assign {head_pat, head_msk} = slots[rd_ptr[P-1:0]];

endmodule

// File: rtl/trig_cond_match.sv
module trig_cond_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] sense,
  input  logic [W-1:0] pattern,
  input  logic [W-1:0] mask,
  output logic         hit
);
  logic [W-1:0] bit_ok;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign bit_ok[b] = !mask[b] || (sense[b] == pattern[b]);
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/trig_chain_fsm.sv
module trig_chain_fsm
  import seq_chain_trigger_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         q_empty,
  input  logic         hit,
  input  logic         enable,
  input  logic         force_req,
  input  logic         clear_req,
  output logic         take,
  output chain_state_e state
);
  chain_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (!q_empty) nxt = ST_LOAD;
      ST_LOAD:  nxt = ST_WAIT;
      ST_WAIT:  if (enable && hit) nxt = q_empty ? ST_FIRED : ST_LOAD;
      ST_FIRED: nxt = ST_FIRED;
      default:  nxt = ST_IDLE;
    endcase
    if (force_req) nxt = ST_FIRED;
    if (clear_req) nxt = ST_IDLE;
  end

  // A pair leaves the queue only when the load step really completes
  assign take = (state == ST_LOAD) && !force_req && !clear_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/seq_chain_trigger.sv
module seq_chain_trigger
  import seq_chain_trigger_pkg::*;
#(
  parameter int TRIG_W = 8,
  parameter int FIFO_P = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [TRIG_W-1:0] cfg_pattern,
  input  logic [TRIG_W-1:0] cfg_mask,
  output logic              cfg_full,
  input  logic [TRIG_W-1:0] trig_in,
  input  logic              enable,
  input  logic              trig_force,
  input  logic              trig_rst,
  output logic              fired,
  output logic              armed
);
  logic [1:0]        rst_pipe;
  logic              rst_ok_n;
  logic [TRIG_W-1:0] head_pat, head_msk;
  logic [TRIG_W-1:0] cur_pat, cur_msk;
  logic              q_empty, take, hit;
  chain_state_e      state;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe[1];

  trig_cond_fifo #(.W(TRIG_W), .P(FIFO_P)) u_queue (
    .clk      (clk),
    .rst_n    (rst_ok_n),
    .push     (cfg_wr),
    .push_pat (cfg_pattern),
    .push_msk (cfg_mask),
    .pop      (take),
    .head_pat (head_pat),
    .head_msk (head_msk),
    .empty    (q_empty),
    .full     (cfg_full)
  );

  // Active condition, loaded with a clock enable on the take step
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      cur_pat <= '0;
      cur_msk <= '0;
    end else if (take) begin
      cur_pat <= head_pat;
      cur_msk <= head_msk;
    end
  end

  trig_cond_match #(.W(TRIG_W)) u_match (
    .sense   (trig_in),
    .pattern (cur_pat),
    .mask    (cur_msk),
    .hit     (hit)
  );

  trig_chain_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .q_empty   (q_empty),
    .hit       (hit),
    .enable    (enable),
    .force_req (trig_force),
    .clear_req (trig_rst),
    .take      (take),
    .state     (state)
  );

  // Force and clear reach the outputs without waiting for a clock edge
  assign fired = ((state == ST_FIRED) || trig_force) && !trig_rst;
  assign armed = (state == ST_WAIT) && !trig_force && !trig_rst;

endmodule

// File: rtl/seq_chain_trigger_chk.sv
module seq_chain_trigger_chk (
  input logic clk,
  input logic rst_ok_n,
  input logic enable,
  input logic trig_force,
  input logic trig_rst,
  input logic fired,
  input logic armed
);

  // R3: armed and fired are never high together
  a_r3_armed_excl: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(armed && fired));

  // R7: force raises the trigger in the same cycle
  a_r7_force_fires: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (trig_force && !trig_rst) |-> fired);

  // R8: clear drops both outputs in the same cycle
  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_ok_n)
    trig_rst |-> (!fired && !armed));

  // R9: the trigger holds until cleared
  a_r9_fired_sticky: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (fired && !trig_rst) |=> (fired || trig_rst));

  // R6: with detection disabled an awaited condition is kept
  a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (armed && !enable) |=> (armed || trig_force || trig_rst));

endmodule

bind seq_chain_trigger seq_chain_trigger_chk u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_ok_n),
  .enable     (enable),
  .trig_force (trig_force),
  .trig_rst   (trig_rst),
  .fired      (fired),
  .armed      (armed)
);

// File: tb/test_seq_chain_trigger.sv
module test_seq_chain_trigger;
  localparam int W = 4;
  localparam int P = 2;
  localparam int DEPTH = 1 << P;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, cfg_wr, enable, trig_force, trig_rst;
  logic [W-1:0] cfg_pattern, cfg_mask, trig_in;
  logic         cfg_full, fired, armed;
  int checks = 0;
  int errors = 0;

  seq_chain_trigger #(.TRIG_W(W), .FIFO_P(P)) i_seq_chain_trigger (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pattern(cfg_pattern),
    .cfg_mask(cfg_mask), .cfg_full(cfg_full), .trig_in(trig_in),
    .enable(enable), .trig_force(trig_force), .trig_rst(trig_rst),
    .fired(fired), .armed(armed)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] p, input logic [W-1:0] m);
    cfg_wr = 1'b1; cfg_pattern = p; cfg_mask = m;
    step();
    cfg_wr = 1'b0;
  endtask

  function automatic logic cond_met(input logic [W-1:0] t, input logic [W-1:0] p,
                                    input logic [W-1:0] m);
    logic ok = 1'b1;
    for (int b = 0; b < W; b++)
      if (m[b] && (t[b] != p[b])) ok = 1'b0;
    return ok;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_pattern = '0; cfg_mask = '0;
    trig_in = '0; enable = 1'b0; trig_force = 1'b0; trig_rst = 1'b0;
    step(); step();
    check("R1 fired in reset", fired, 1'b0);
    check("R1 armed in reset", armed, 1'b0);
    check("R1 full in reset", cfg_full, 1'b0);
    rst_n = 1'b1;
    step(); step(); step();
    check("R1 armed after release", armed, 1'b0);
    check("R1 fired after release", fired, 1'b0);

    // Single-condition sweep over every mask, pattern and input (R3 R4 R6 R10)
    for (int m = 0; m < (1 << W); m++) begin
      for (int p = 0; p < (1 << W); p++) begin
        for (int t = 0; t < (1 << W); t++) begin
          logic exp;
          trig_rst = 1'b1; step(); trig_rst = 1'b0;
          push(W'(p), W'(m));
          step(); step();
          check("R3 armed two edges after write", armed, 1'b1);
          exp = cond_met(W'(t), W'(p), W'(m));
          trig_in = W'(t);
          if (exp) begin
            enable = 1'b0;
            step();
            check("R6 armed held with enable low", armed, 1'b1);
            check("R6 no fire with enable low", fired, 1'b0);
          end
          enable = 1'b1;
          step();
          if (m == 0) check("R10 empty mask fires", fired, 1'b1);
          else        check("R4 masked compare fired", fired, exp);
          check("R4 masked compare armed", armed, !exp);
          enable = 1'b0;
        end
      end
    end

    // Load a chain while forced high; fifth write overflows (R2 R5 R7 R9)
    trig_rst = 1'b1; step(); trig_rst = 1'b0;
    trig_force = 1'b1; #1;
    check("R7 force immediate", fired, 1'b1);
    step();
    push(4'h1, 4'hF);
    push(4'h2, 4'hF);
    push(4'h3, 4'hF);
    push(4'hA, 4'hA);
    check("R2 full at depth", cfg_full, 1'b1);
    push(4'h5, 4'hF);
    check("R2 full after dropped write", cfg_full, 1'b1);
    trig_force = 1'b0;
    step();
    check("R9 fired held after force", fired, 1'b1);
    trig_rst = 1'b1; #1;
    check("R8 clear drops fired", fired, 1'b0);
    check("R8 clear drops armed", armed, 1'b0);
    step(); trig_rst = 1'b0;
    step(); step();
    check("R3 armed on first queued pair", armed, 1'b1);
    enable = 1'b1;
    trig_in = 4'h2; step();
    check("R5 later condition ignored", armed, 1'b1);
    trig_in = 4'h1; step();
    check("R5 load gap armed low", armed, 1'b0);
    check("R5 not fired mid chain", fired, 1'b0);
    step();
    check("R5 armed for second pair", armed, 1'b1);
    trig_in = 4'h2; step(); step();
    check("R5 armed for third pair", armed, 1'b1);
    trig_in = 4'h3; step(); step();
    check("R5 armed for fourth pair", armed, 1'b1);
    trig_in = 4'hE; step();
    check("R2 chain ends without dropped pair", fired, 1'b1);
    check("R2 not armed after last pair", armed, 1'b0);
    enable = 1'b0;
    step(); step();
    check("R9 fired sticky", fired, 1'b1);

    // Clear wins over force (R8)
    trig_force = 1'b1; trig_rst = 1'b1; #1;
    check("R8 clear beats force", fired, 1'b0);
    step(); trig_rst = 1'b0; #1;
    check("R7 force after clear", fired, 1'b1);
    step(); trig_force = 1'b0; #1;
    check("R9 fired held after forced edge", fired, 1'b1);

    // Force from waiting with enable low (R7)
    trig_rst = 1'b1; step(); trig_rst = 1'b0;
    push(4'h0, 4'hF);
    step(); step();
    check("R3 armed before force", armed, 1'b1);
    trig_in = 4'h7; trig_force = 1'b1; #1;
    check("R7 force with enable low", fired, 1'b1);
    check("R7 force drops armed", armed, 1'b0);
    step(); trig_force = 1'b0; #1;
    check("R7 fired state after force", fired, 1'b1);

    // Asynchronous reset (R1)
    rst_n = 1'b0; #1;
    check("R1 async reset clears fired", fired, 1'b0);
    check("R1 async reset clears full", cfg_full, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule